// File: doc/BRIEF.md
# Per-Register Instance Counter Tag Generator

This block hands out operand tags for an in-order queue of instructions that may finish out of order. Every architectural register keeps two small counters. One counts how many accepted instructions that write the register have not yet retired. The other holds the instance number of the most recent such writer. A register's tag is its index with that instance number appended, so the issue stage builds tags by indexing and concatenating. There is no tag table and no associative search.

At issue, each source port reads a register and gets back the current tag of that register and a flag. The flag is high when no writer is outstanding, which means the operand is taken from the register file. A destination request takes a fresh tag: the instance number moves forward by one and wraps at its range, and the outstanding count goes up. When a writer leaves the queue, the commit port lowers that register's outstanding count. A request is held off whenever the destination's outstanding count is already at its ceiling, because a new instance number could then collide with a live one.

Top module: `itag_gen`

## Requirements
- R1: After reset every register reads as idle: `busy_vec` is all zero, every `src_from_rf` bit is 1, and every source tag carries instance number 0.
- R2: A source port returns `{register index, latest instance}`, with the index in the upper `IDX_W` bits and the instance in the lower `CNT_W` bits. `src_from_rf` is 1 exactly when that register has no outstanding writer.
- R3: When a destination request is accepted, `dst_tag` shows `{dst_idx, latest instance + 1}` in that same cycle. From the next cycle, source reads of that register return this tag and report it busy.
- R4: The latest-instance number wraps modulo 2^CNT_W. With CNT_W=3, the step after 7 is 0.
- R5: `busy_vec[r]` is 1 while register r has at least one outstanding writer. Each commit on `cmt_vld`/`cmt_idx` removes one, and the bit clears once commits match accepted writes. Commits only target busy registers.
- R6: `issue_stall` is 1 when `dst_req` is high and the destination's outstanding count equals 2^CNT_W−1. A stalled request changes neither counter of any register.
- R7: An accepted write and a commit to the same register in one cycle leave its outstanding count unchanged, and the latest-instance number still advances.
- R8: A source read of a register in the same cycle as an accepted write to it returns the tag from before the increment.
- R9: Writes and commits to one register leave every other register's tag and busy state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_req | input | 1 | An instruction with a destination register asks for a tag |
| dst_idx | input | IDX_W | Destination register index |
| dst_tag | output | IDX_W+CNT_W | Tag assigned to the requesting writer |
| issue_stall | output | 1 | Request refused: destination counter at its ceiling |
| cmt_vld | input | 1 | A writer of a register leaves the queue |
| cmt_idx | input | IDX_W | Register written by the retiring instruction |
| src_idx | input | NUM_SRC*IDX_W | Source register indices, port k at bits [k*IDX_W +: IDX_W] |
| src_tag | output | NUM_SRC*(IDX_W+CNT_W) | Current tag per source port |
| src_from_rf | output | NUM_SRC | Source operand comes from the register file |
| busy_vec | output | NUM_REGS | Per-register outstanding-writer flag |

## Verification
The hardest case to reach from the ports is a destination sitting at its outstanding ceiling while its instance number wraps. To get there, one register must take seven accepted writes with no commit in between. Then a stalled request must be shown to leave the state alone, and after one commit the next accepted write must show an instance number of 0. A directed sequence builds exactly this. A second directed case puts a write and a commit on the same register in one cycle and reads that register on a source port in that cycle. After the directed cases, a long random phase with legal commits is compared against a behavioural model on every clock.

// File: rtl/itag_pkg.sv
package itag_pkg;

  // Per-register counter control for one cycle.
  typedef struct packed {
    logic inc;
    logic dec;
  } itag_ctl_t;

endpackage

// File: rtl/itag_cnt_slice.sv
module itag_cnt_slice
  import itag_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  itag_ctl_t        ctl,
  output logic [CNT_W-1:0] latest,
  output logic             busy,
  output logic             full
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] outst_q, outst_d;
  logic [CNT_W-1:0] lat_q, lat_d;
  logic             cnt_en;

  always_comb begin
    outst_d = outst_q;
    lat_d   = lat_q;
    cnt_en  = ctl.inc | ctl.dec;
    unique case ({ctl.inc, ctl.dec})
      2'b10:   outst_d = outst_q + 1'b1;
      2'b01:   outst_d = outst_q - 1'b1;
      default: outst_d = outst_q;
    endcase
    if (ctl.inc) begin
      lat_d = lat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= '0;
      lat_q   <= '0;
    end else if (cnt_en) begin
      outst_q <= outst_d;
      lat_q   <= lat_d;
    end
  end

  assign latest = lat_q;
  assign busy   = |outst_q;
  assign full   = (outst_q == CNT_MAX);

endmodule

// File: rtl/itag_decode.sv
module itag_decode
  import itag_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                dst_req,
  input  logic [IDX_W-1:0]    dst_idx,
  input  logic                cmt_vld,
  input  logic [IDX_W-1:0]    cmt_idx,
  input  logic [NUM_REGS-1:0] full_vec,
  output itag_ctl_t           ctl [NUM_REGS],
  output logic                stall
);

  logic accept;

  always_comb begin
    stall  = dst_req & full_vec[dst_idx];
    accept = dst_req & ~stall;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
    always_comb begin
      ctl[r].inc = accept  & (dst_idx == IDX_W'(r));
      ctl[r].dec = cmt_vld & (cmt_idx == IDX_W'(r));
    end
  end

endmodule

// File: rtl/itag_src_port.sv
module itag_src_port #(
  parameter int NUM_REGS = 8,
  parameter int CNT_W    = 3,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int TAG_W   = IDX_W + CNT_W
) (
  input  logic [IDX_W-1:0]                rd_idx,
  input  logic [NUM_REGS-1:0][CNT_W-1:0]  lat_arr,
  input  logic [NUM_REGS-1:0]             busy_vec,
  output logic [TAG_W-1:0]                rd_tag,
  output logic                            rd_from_rf
);

  always_comb begin
    rd_tag     = {rd_idx, lat_arr[rd_idx]};
    rd_from_rf = ~busy_vec[rd_idx];
  end

endmodule

// File: rtl/itag_gen.sv
module itag_gen
  import itag_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int CNT_W    = 3,
  parameter int NUM_SRC  = 2,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int TAG_W   = IDX_W + CNT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dst_req,
  input  logic [IDX_W-1:0]           dst_idx,
  output logic [TAG_W-1:0]           dst_tag,
  output logic                       issue_stall,
  input  logic                       cmt_vld,
  input  logic [IDX_W-1:0]           cmt_idx,
  input  logic [NUM_SRC*IDX_W-1:0]   src_idx,
  output logic [NUM_SRC*TAG_W-1:0]   src_tag,
  output logic [NUM_SRC-1:0]         src_from_rf,
  output logic [NUM_REGS-1:0]        busy_vec
);

  itag_ctl_t                       ctl [NUM_REGS];
  logic [NUM_REGS-1:0][CNT_W-1:0]  lat_arr;
  logic [NUM_REGS-1:0]             full_vec;
  logic [NUM_REGS-1:0]             busy_int;

  itag_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .dst_req  (dst_req),
    .dst_idx  (dst_idx),
    .cmt_vld  (cmt_vld),
    .cmt_idx  (cmt_idx),
    .full_vec (full_vec),
    .ctl      (ctl),
    .stall    (issue_stall)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    itag_cnt_slice #(.CNT_W(CNT_W)) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (ctl[r]),
      .latest (lat_arr[r]),
      .busy   (busy_int[r]),
      .full   (full_vec[r])
    );
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    itag_src_port #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_port (
      .rd_idx     (src_idx[k*IDX_W +: IDX_W]),
      .lat_arr    (lat_arr),
      .busy_vec   (busy_int),
      .rd_tag     (src_tag[k*TAG_W +: TAG_W]),
      .rd_from_rf (src_from_rf[k])
    );
  end

  always_comb begin
    dst_tag  = {dst_idx, CNT_W'(lat_arr[dst_idx] + 1'b1)};
    busy_vec = busy_int;
  end

endmodule

// File: rtl/itag_gen_chk.sv
module itag_gen_chk #(
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dst_req,
  input logic [IDX_W-1:0]    dst_idx,
  input logic                issue_stall,
  input logic                cmt_vld,
  input logic [IDX_W-1:0]    cmt_idx,
  input logic [NUM_REGS-1:0] busy_vec
);

  // R6
  stall_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stall |-> dst_req);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_req && issue_stall && !cmt_vld) |=> $stable(busy_vec));

  // R5
  cmt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_vld |-> busy_vec[cmt_idx]);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    // R5
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_vec[r]) |-> $past(dst_req && !issue_stall && (dst_idx == IDX_W'(r))));

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_vec[r]) |-> $past(cmt_vld && (cmt_idx == IDX_W'(r))));
  end

endmodule

bind itag_gen itag_gen_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dst_req     (dst_req),
  .dst_idx     (dst_idx),
  .issue_stall (issue_stall),
  .cmt_vld     (cmt_vld),
  .cmt_idx     (cmt_idx),
  .busy_vec    (busy_vec)
);

// File: tb/itag_gen_tb.sv
`timescale 1ns/100ps
module itag_gen_tb;

  localparam int NR = 8;
  localparam int CW = 3;
  localparam int NS = 2;
  localparam int IW = 3;
  localparam int TW = IW + CW;
  localparam int CMAX = (1 << CW) - 1;

  logic           clk;
  logic           rst_n;
  logic           dst_req;
  logic [IW-1:0]  dst_idx;
  logic [TW-1:0]  dst_tag;
  logic           issue_stall;
  logic           cmt_vld;
  logic [IW-1:0]  cmt_idx;
  logic [NS*IW-1:0] src_idx;
  logic [NS*TW-1:0] src_tag;
  logic [NS-1:0]  src_from_rf;
  logic [NR-1:0]  busy_vec;

  int m_cnt [NR];
  int m_lat [NR];
  int n_chk;
  int n_fail;

  itag_gen #(.NUM_REGS(NR), .CNT_W(CW), .NUM_SRC(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .dst_req(dst_req), .dst_idx(dst_idx),
    .dst_tag(dst_tag), .issue_stall(issue_stall), .cmt_vld(cmt_vld),
    .cmt_idx(cmt_idx), .src_idx(src_idx), .src_tag(src_tag),
    .src_from_rf(src_from_rf), .busy_vec(busy_vec)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int tag_of(input int r, input int l);
    return (r << CW) | (l % (1 << CW));
  endfunction

  function automatic int stag(input int k);
    return int'(src_tag[k*TW +: TW]);
  endfunction

  // Drive one cycle's inputs after the falling edge, then settle.
  task automatic drive(input logic dr, input int di, input logic cv, input int ci,
                       input int s0, input int s1);
    @(negedge clk);
    dst_req = dr; dst_idx = IW'(di);
    cmt_vld = cv; cmt_idx = IW'(ci);
    src_idx = {IW'(s1), IW'(s0)};
    #1;
  endtask

  // Compare all outputs with the model, then advance both on the edge.
  task automatic tick();
    int bexp;
    bit acc;
    bexp = 0;
    for (int r = 0; r < NR; r++) if (m_cnt[r] > 0) bexp |= (1 << r);
    chk("R5 busy", int'(busy_vec), bexp);
    chk("R6 stall", int'(issue_stall), int'(dst_req && m_cnt[dst_idx] == CMAX));
    if (dst_req && m_cnt[dst_idx] != CMAX)
      chk("R3 dst_tag", int'(dst_tag), tag_of(dst_idx, m_lat[dst_idx] + 1));
    for (int k = 0; k < NS; k++) begin
      int ri;
      ri = int'(src_idx[k*IW +: IW]);
      chk("R2 src_tag", stag(k), tag_of(ri, m_lat[ri]));
      chk("R2 src_from_rf", int'(src_from_rf[k]), int'(m_cnt[ri] == 0));
    end
    acc = dst_req && (m_cnt[dst_idx] != CMAX);
    @(posedge clk);
    if (acc) begin
      m_lat[dst_idx] = (m_lat[dst_idx] + 1) % (1 << CW);
      m_cnt[dst_idx]++;
    end
    if (cmt_vld) m_cnt[cmt_idx]--;
  endtask

  initial begin
    #1000000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    for (int r = 0; r < NR; r++) begin m_cnt[r] = 0; m_lat[r] = 0; end
    rst_n = 1'b0; dst_req = 1'b0; dst_idx = '0; cmt_vld = 1'b0; cmt_idx = '0; src_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: idle state after reset
    drive(0, 0, 0, 0, 2, 7);
    chk("R1 busy", int'(busy_vec), 0);
    chk("R1 from_rf", int'(src_from_rf), 3);
    chk("R1 tag0", stag(0), tag_of(2, 0));
    chk("R1 tag1", stag(1), tag_of(7, 0));
    tick();

    // R8: same-cycle read returns pre-increment tag
    drive(1, 3, 0, 0, 3, 3);
    chk("R8 src tag", stag(0), tag_of(3, 0));
    chk("R8 from_rf", int'(src_from_rf[0]), 1);
    chk("R3 new tag", int'(dst_tag), tag_of(3, 1));
    tick();
    drive(0, 0, 0, 0, 3, 5);
    chk("R3 tag visible", stag(0), tag_of(3, 1));
    chk("R3 busy", int'(src_from_rf[0]), 0);
    tick();

    // R9: other registers untouched
    drive(1, 5, 0, 0, 3, 5);
    tick();
    drive(0, 0, 0, 0, 3, 5);
    chk("R9 r3 tag", stag(0), tag_of(3, 1));
    chk("R9 r5 tag", stag(1), tag_of(5, 1));
    chk("R9 busy", int'(busy_vec), 8'h28);
    tick();

    // R7: write and commit on r3 together
    drive(1, 3, 1, 3, 3, 3);
    tick();
    drive(0, 0, 0, 0, 3, 3);
    chk("R7 still busy", int'(busy_vec[3]), 1);
    chk("R7 latest advanced", stag(0), tag_of(3, 2));
    tick();
    drive(0, 0, 1, 3, 3, 3);
    tick();
    drive(0, 0, 1, 5, 3, 5);
    chk("R5 r3 cleared", int'(busy_vec[3]), 0);
    tick();

    // R6 / R4: fill r6 to its ceiling, stall, then wrap
    for (int i = 0; i < CMAX; i++) begin drive(1, 6, 0, 0, 6, 0); tick(); end
    drive(1, 6, 0, 0, 6, 0);
    chk("R6 stall at max", int'(issue_stall), 1);
    tick();
    drive(0, 0, 0, 0, 6, 0);
    chk("R6 no change", stag(0), tag_of(6, 7));
    tick();
    drive(0, 0, 1, 6, 6, 0);
    tick();
    drive(1, 6, 0, 0, 6, 0);
    chk("R6 accepted after commit", int'(issue_stall), 0);
    chk("R4 wrap", int'(dst_tag), tag_of(6, 0));
    tick();
    for (int i = 0; i < CMAX; i++) begin drive(0, 0, 1, 6, 6, 0); tick(); end
    drive(0, 0, 0, 0, 6, 0);
    chk("R5 r6 drained", int'(busy_vec), 0);
    chk("R4 wrapped tag held", stag(0), tag_of(6, 0));
    tick();

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      int di, ci;
      logic dr, cv;
      dr = ($urandom % 3) != 0;
      di = $urandom % 4;
      ci = $urandom % NR;
      cv = (($urandom % 2) == 1) && (m_cnt[ci] > 0);
      drive(dr, di, cv, ci, $urandom % NR, di);
      tick();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule